// File: doc/BRIEF.md
# SPI Phase-0 Master Clock Engine

This block runs one master-side SPI character exchange at a time, clocked entirely from the slow peripheral clock. A start strobe captures a transmit word, a 7-bit baud code and a polarity bit. The engine then produces the serial clock, shifts the word out on MOSI most significant bit first, and collects the same number of bits from MISO. When the exchange ends it presents the received word and raises a one-cycle completion flag.

The serial clock period, counted in peripheral-clock cycles, comes from the baud code. Codes 0 through 3 give a period of 4. Any larger code gives a period of code+1. When the period is odd, the two halves of each serial clock cycle differ by one peripheral cycle. The level away from idle always gets the shorter half, whichever polarity is chosen. Only clock phase 0 is supported. In this mode data leaves on the edge that moves away from the idle level and is sampled on the edge that returns to it.

Top module: `spi_ph0_master`

## Requirements
- R1: Each bit takes N peripheral cycles, where N = 4 for a baud code of 0, 1, 2 or 3 and N = code + 1 for a baud code from 4 to 127.
- R2: Within each bit the clock spends floor(N/2) cycles at the non-idle level followed by ceil(N/2) cycles at the idle level. Before the first bit there is a lead-in of ceil(N/2) idle cycles, so the first edge away from idle comes ceil(N/2) cycles after the start edge.
- R3: The idle clock level equals the polarity bit (0 = idle low, 1 = idle high). While no exchange is running, sclk_o follows cpol_i one cycle late.
- R4: MOSI carries the transmit word's MSB from the start edge onward. Every later bit appears on the edge that moves the clock away from idle, and bits go out MSB first.
- R5: MISO is sampled on each edge that returns the clock to idle. The first sample becomes bit DATA_W-1 of rx_data_o.
- R6: Exactly DATA_W*N + ceil(N/2) cycles after the start edge, done_o is high for one cycle. On that same edge the clock settles at idle, mosi_o goes low and rx_data_o takes the received word.
- R7: While an exchange is running, start_i, tx_data_i, baud_i and cpol_i have no effect on the exchange.
- R8: While rst_ni is low, sclk_o, mosi_o, done_o and rx_data_o are all 0 and no exchange is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| baud_i | input | 7 | Baud code, captured at start |
| cpol_i | input | 1 | Clock polarity / idle level |
| start_i | input | 1 | Start strobe, honoured only when idle |
| tx_data_i | input | DATA_W | Word to transmit |
| miso_i | input | 1 | Serial data from the slave |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to the slave |
| rx_data_o | output | DATA_W | Last received word |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The reference model counts the peripheral edges since the accepted start and uses that count to predict the output levels. The first idle-to-active transition is due ceil(N/2) edges after start, and each bit lasts N edges after that. The completion pulse and the received word are due at edge DATA_W*N + ceil(N/2). Inputs change only on falling clock edges, and all outputs are compared on the falling edge that follows the rising edge where the model advanced, so every registered result is checked in the cycle it first becomes visible. The slave data on MISO follows the same count, so each bit stays stable across its sampling edge.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  localparam int BAUD_W = 7;
  localparam int DIV_W  = BAUD_W + 1;

  // baud code -> peripheral cycles per serial bit; small codes clamp to 4
  function automatic logic [DIV_W-1:0] div_of(input logic [BAUD_W-1:0] code);
    if (code < BAUD_W'(4)) return DIV_W'(4);
    return {1'b0, code} + DIV_W'(1);
  endfunction
endpackage

// File: rtl/spi_clk_timer.sv
module spi_clk_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             run_i,
  output logic             act_o,
  output logic             end_o
);
  logic [DIV_W-1:0] cnt_q, hi_q, lo_q;
  logic             act_q;
  logic [DIV_W-1:0] hi_d, lo_d;

  assign hi_d  = div_i >> 1;
  assign lo_d  = div_i - hi_d;
  assign end_o = run_i && (cnt_q == '0);
  assign act_o = act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      hi_q  <= '0;
      lo_q  <= '0;
      act_q <= 1'b0;
    end else if (load_i) begin
      hi_q  <= hi_d;
      lo_q  <= lo_d;
      cnt_q <= lo_d - DIV_W'(1);  // lead-in idle half
      act_q <= 1'b0;
    end else if (end_o) begin
      act_q <= ~act_q;
      cnt_q <= act_q ? lo_q - DIV_W'(1) : hi_q - DIV_W'(1);
    end else if (run_i) begin
      cnt_q <= cnt_q - DIV_W'(1);
    end
  end
endmodule

// File: rtl/spi_shift.sv
module spi_shift #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              shift_i,
  input  logic              clr_i,
  input  logic              sample_i,
  input  logic              miso_i,
  output logic              mosi_o,
  output logic [DATA_W-1:0] rx_o
);
  logic [DATA_W-1:0] tx_q, rx_q;

  assign mosi_o = tx_q[DATA_W-1];
  assign rx_o   = rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q <= '0;
    end else if (load_i) begin
      tx_q <= data_i;
    end else if (clr_i) begin
      tx_q <= '0;
    end else if (shift_i) begin
      tx_q <= tx_q << 1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_q <= '0;
    end else if (sample_i) begin
      rx_q <= {rx_q[DATA_W-2:0], miso_i};
    end
  end
endmodule

// File: rtl/spi_ph0_master.sv
module spi_ph0_master
  import spi_eng_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BAUD_W-1:0] baud_i,
  input  logic              cpol_i,
  input  logic              start_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              miso_i,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              done_o
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  logic             busy_q, pol_q, sclk_q, done_q;
  logic [CNT_W-1:0] bit_cnt_q;
  logic [DATA_W-1:0] rx_q, rx_sh;
  logic             act, ph_end, launch, rise, fall, last, finish, shift_tx;

  assign launch   = start_i && !busy_q;
  assign rise     = ph_end && !act;
  assign fall     = ph_end && act;
  assign last     = (bit_cnt_q == CNT_W'(DATA_W));
  assign finish   = rise && last;
  assign shift_tx = rise && !last && (bit_cnt_q != '0);

  spi_clk_timer #(.DIV_W(DIV_W)) i_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(launch),
    .div_i (div_of(baud_i)),
    .run_i (busy_q),
    .act_o (act),
    .end_o (ph_end)
  );

  spi_shift #(.DATA_W(DATA_W)) i_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (launch),
    .data_i  (tx_data_i),
    .shift_i (shift_tx),
    .clr_i   (finish),
    .sample_i(fall),
    .miso_i  (miso_i),
    .mosi_o  (mosi_o),
    .rx_o    (rx_sh)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      pol_q     <= 1'b0;
      sclk_q    <= 1'b0;
      done_q    <= 1'b0;
      bit_cnt_q <= '0;
      rx_q      <= '0;
    end else begin
      done_q <= finish;
      if (launch) begin
        busy_q    <= 1'b1;
        pol_q     <= cpol_i;
        sclk_q    <= cpol_i;
        bit_cnt_q <= '0;
      end else if (!busy_q) begin
        sclk_q <= cpol_i;
      end else if (finish) begin
        busy_q <= 1'b0;
        sclk_q <= pol_q;
        rx_q   <= rx_sh;
      end else if (rise) begin
        sclk_q <= ~pol_q;
      end else if (fall) begin
        sclk_q    <= pol_q;
        bit_cnt_q <= bit_cnt_q + CNT_W'(1);
      end
    end
  end

  assign sclk_o    = sclk_q;
  assign done_o    = done_q;
  assign rx_data_o = rx_q;
endmodule

// File: rtl/spi_ph0_chk.sv
module spi_ph0_chk #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             busy_i,
  input logic             act_i,
  input logic             pol_i,
  input logic [CNT_W-1:0] bit_cnt_i,
  input logic             sclk_o,
  input logic             mosi_o,
  input logic             done_o
);
  assert_clk_phase_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> (sclk_o == (act_i ^ pol_i)));

  assert_pol_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i)) |-> $stable(pol_i));

  assert_mosi_edge_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i) && $stable(sclk_o)) |-> $stable(mosi_o));

  assert_done_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_i && !mosi_o && $past(busy_i)));

  assert_bit_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_cnt_i <= CNT_W'(DATA_W));
endmodule

bind spi_ph0_master spi_ph0_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .busy_i   (busy_q),
  .act_i    (act),
  .pol_i    (pol_q),
  .bit_cnt_i(bit_cnt_q),
  .sclk_o   (sclk_o),
  .mosi_o   (mosi_o),
  .done_o   (done_o)
);

// File: tb/test_spi_ph0_master.sv
`timescale 1ns/1ps
module test_spi_ph0_master;
  localparam int D = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [6:0]    baud = '0;
  logic          cpol = 1'b0;
  logic          start = 1'b0;
  logic [D-1:0]  tx = '0;
  logic          miso = 1'b0;
  logic          sclk, mosi, done;
  logic [D-1:0]  rx;

  int total = 0, bad = 0, cycles = 0;
  bit chk_en = 1'b0;
  string tag7 = "";

  // reference model state
  bit           m_busy = 1'b0;
  int           t, n, h, l;
  bit           m_pol;
  logic [D-1:0] m_tx, m_slv, slave_word;
  logic         e_sclk = 1'b0, e_mosi = 1'b0, e_done = 1'b0;
  logic [D-1:0] e_rx = '0;

  always #2.5 clk = ~clk;

  spi_ph0_master #(.DATA_W(D)) i_spi_ph0_master (
    .clk_i(clk), .rst_ni(rst_n), .baud_i(baud), .cpol_i(cpol), .start_i(start),
    .tx_data_i(tx), .miso_i(miso), .sclk_o(sclk), .mosi_o(mosi),
    .rx_data_o(rx), .done_o(done)
  );

  task automatic chk(input string req, input logic [D-1:0] act, input logic [D-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s t=%0d actual=%h expected=%h", req, t, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rst_n) begin
      e_done = 1'b0;
      if (m_busy) begin
        t++;
        if (t == D*n + l) begin
          m_busy = 1'b0;
          e_done = 1'b1;
          e_rx   = m_slv;
          e_mosi = 1'b0;
          e_sclk = m_pol;
        end else begin
          e_sclk = ((t >= l) && (((t - l) % n) < h)) ? !m_pol : m_pol;
          e_mosi = (t < l) ? m_tx[D-1] : m_tx[D-1-((t-l)/n)];
        end
      end else if (start) begin
        m_busy = 1'b1;
        t = 0;
        n = (baud < 4) ? 4 : int'(baud) + 1;
        h = n / 2;
        l = n - h;
        m_pol = cpol;
        m_tx = tx;
        m_slv = slave_word;
        e_sclk = cpol;
        e_mosi = tx[D-1];
      end else begin
        e_sclk = cpol;
      end
    end
  end

  // slave drives MISO from the model's own bit count; compare outputs
  always @(negedge clk) begin
    if (m_busy && t >= l) miso <= m_slv[D-1-((t-l)/n)];
    if (chk_en) begin
      chk(tag7 != "" ? tag7 : (m_busy ? "R1 R2" : "R3"), D'(sclk), D'(e_sclk));
      chk(tag7 != "" ? tag7 : "R4", D'(mosi), D'(e_mosi));
      chk("R6", D'(done), D'(e_done));
      if (e_done) chk("R5", rx, e_rx);
    end
  end

  task automatic xfer(input logic [6:0] b, input logic p, input logic [D-1:0] w,
                      input logic [D-1:0] s, input bit poke);
    @(negedge clk);
    baud = b; cpol = p; tx = w; slave_word = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      tag7 = "R7";
      repeat (7) @(negedge clk);
      baud = ~b; cpol = ~p; tx = ~w; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (3) @(negedge clk);
      cpol = p;
    end
    while (m_busy) @(negedge clk);
    tag7 = "";
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R8", D'(sclk), '0);
    chk("R8", D'(mosi), '0);
    chk("R8", D'(done), '0);
    chk("R8", rx, '0);
    rst_n = 1'b1;
    chk_en = 1'b1;
    repeat (3) @(negedge clk);
    xfer(7'd0,   1'b0, 16'hA5C3, 16'h3C5A, 1'b0);
    xfer(7'd2,   1'b1, 16'h8001, 16'hFFFF, 1'b0);
    xfer(7'd3,   1'b0, 16'h7FFE, 16'h0001, 1'b0);
    xfer(7'd4,   1'b0, 16'h1234, 16'hBEEF, 1'b0);
    xfer(7'd4,   1'b1, 16'hF00F, 16'h8421, 1'b0);
    xfer(7'd9,   1'b1, 16'h0F0F, 16'hC001, 1'b1);
    xfer(7'd6,   1'b0, 16'hDEAD, 16'h5555, 1'b1);
    xfer(7'd127, 1'b0, 16'hCAFE, 16'h9A3C, 1'b0);
    cpol = 1'b1;
    repeat (4) @(negedge clk);
    chk_en = 1'b0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule